// File: doc/BRIEF.md
# Fault Interrupt Status Controller

This block gathers single-cycle fault pulses from the supply and thermal monitors (power-good loss, over-voltage, over-temperature shutdown and undervoltage lockout) into a sticky status register. It drives an active-low, open-drain style interrupt line. The line is modelled as an enable that pulls the line low; when the enable is off the line floats and an external pull-up holds it high.

A mask register decides which pending faults may pull the interrupt line. The mask changes only the interrupt line. A masked fault still latches its status bit, so software polling the status register sees every fault. Software reads the status through a small register port. The read returns the current bits and clears every bit it returned as set. A fault that arrives in the same cycle as that read is kept for the next read.

Top module: `fault_irq_ctrl`

## Requirements
- R1: After reset, status reads 0, mask reads all ones, and `irq_pull_en` is 0.
- R2: A one-cycle pulse on `evt[i]` sets status bit i from the next clock edge. The bit map is bit 0 power-good fault, bit 1 over-voltage, bit 2 over-temperature, bit 3 undervoltage lockout.
- R3: A pulse on a source whose mask bit is 1 still sets its status bit.
- R4: `irq_pull_en` is 1 exactly when some status bit is 1 and its mask bit is 0.
- R5: A set status bit stays set until the status register is read.
- R6: A read at address 0 (`reg_re`=1, `reg_addr`=0) returns the status combinationally. At the clock edge it clears every bit that read returned as 1.
- R7: An event pulse in the same cycle as a clearing read leaves its status bit set after that edge.
- R8: A write at address 1 loads `reg_wdata` into the mask from the next edge. A read at address 1 returns the mask and leaves the status unchanged.
- R9: A write at address 0 has no effect on the status.
- R10: A change of mask never alters the status. Unmasking a pending bit raises `irq_pull_en` from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt | input | N_SRC | Fault event pulses, one per source |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 1 | 0 = status, 1 = mask |
| reg_wdata | input | N_SRC | Write data |
| reg_rdata | output | N_SRC | Read data, combinational from `reg_addr` |
| irq_pull_en | output | 1 | 1 = pull the interrupt line low, 0 = release it |

## Verification
On every cycle, the assertions check several properties:
- Every event pulse is latched into status, whether or not it is masked.
- Status bits never drop without a clearing read.
- A clearing read leaves only the bits that arrived during that read.
- Mask writes land on the next edge.
- A fully masked register never pulls the line.

Only the bench scenarios can show the rest:
- The value a read returns before its clear takes effect.
- The ordering between a read and a coincident event, seen across two successive reads.
- A write to the status address being ignored.
- A pending fault pulling the line the moment it is unmasked.

// File: rtl/fault_irq_ctrl.sv
module fault_irq_ctrl #(
  parameter int N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt,
  input  logic             reg_we,
  input  logic             reg_re,
  input  logic             reg_addr,
  input  logic [N_SRC-1:0] reg_wdata,
  output logic [N_SRC-1:0] reg_rdata,
  output logic             irq_pull_en
);

  localparam logic ADDR_STATUS = 1'b0;
  localparam logic ADDR_MASK   = 1'b1;

  logic [N_SRC-1:0] status_q;
  logic [N_SRC-1:0] mask_q;
  logic [N_SRC-1:0] clr_bits;

  assign clr_bits    = (reg_re && reg_addr == ADDR_STATUS) ? status_q : '0;
  assign reg_rdata   = (reg_addr == ADDR_MASK) ? mask_q : status_q;
  assign irq_pull_en = |(status_q & ~mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '1;
    end else begin
      status_q <= (status_q & ~clr_bits) | evt;
      if (reg_we && reg_addr == ADDR_MASK) mask_q <= reg_wdata;
    end
  end

endmodule

// File: rtl/fault_irq_ctrl_chk.sv
module fault_irq_ctrl_chk #(
  parameter int N_SRC = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] evt,
  input logic             reg_we,
  input logic             reg_re,
  input logic             reg_addr,
  input logic [N_SRC-1:0] reg_wdata,
  input logic             irq_pull_en,
  input logic [N_SRC-1:0] status_q,
  input logic [N_SRC-1:0] mask_q
);

  logic clr_rd;
  assign clr_rd = reg_re && (reg_addr == 1'b0);

  AST_EVT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((status_q & $past(evt)) == $past(evt))); // R3

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_rd |=> ((status_q & $past(status_q)) == $past(status_q))); // R5

  AST_CLEAR_KEEPS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    clr_rd |=> (status_q == $past(evt))); // R7

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr) |=> (mask_q == $past(reg_wdata))); // R8

  AST_FULL_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !irq_pull_en); // R4

endmodule

bind fault_irq_ctrl fault_irq_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt(evt), .reg_we(reg_we), .reg_re(reg_re),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .irq_pull_en(irq_pull_en),
  .status_q(status_q), .mask_q(mask_q)
);

// File: tb/fault_irq_ctrl_bench.sv
module fault_irq_ctrl_bench;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] evt = '0;
  logic         reg_we = 1'b0;
  logic         reg_re = 1'b0;
  logic         reg_addr = 1'b0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata;
  logic         irq_pull_en;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  fault_irq_ctrl #(.N_SRC(N)) u_fault_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .evt(evt), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_pull_en(irq_pull_en)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle(input logic [N-1:0] e);
    evt = e;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic wr(input logic a, input logic [N-1:0] d, input logic [N-1:0] e);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d; evt = e;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0; evt = '0;
  endtask

  task automatic rd(input logic a, input logic [N-1:0] e, output logic [N-1:0] d);
    reg_re = 1'b1; reg_addr = a; evt = e;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0; evt = '0;
  endtask

  task automatic t_reset();
    logic [N-1:0] d;
    check("R1 irq", irq_pull_en, 0);
    rd(1'b0, '0, d); check("R1 status", d, 4'h0);
    rd(1'b1, '0, d); check("R1 mask", d, 4'hF);
  endtask

  task automatic t_unmasked_event();
    logic [N-1:0] d;
    wr(1'b1, 4'h0, '0);
    idle(4'b0010);
    check("R4 irq after ov", irq_pull_en, 1);
    rd(1'b0, '0, d); check("R2 R6 status read", d, 4'b0010);
    check("R6 irq after clear", irq_pull_en, 0);
    rd(1'b0, '0, d); check("R6 cleared", d, 4'h0);
  endtask

  task automatic t_masked_event();
    logic [N-1:0] d;
    wr(1'b1, 4'b1110, '0);
    idle(4'b0100);
    check("R3 R4 masked irq quiet", irq_pull_en, 0);
    rd(1'b0, '0, d); check("R3 masked still latched", d, 4'b0100);
    idle(4'b0001);
    check("R4 unmasked bit0 irq", irq_pull_en, 1);
    rd(1'b0, '0, d); check("R2 pg bit", d, 4'b0001);
  endtask

  task automatic t_sticky();
    logic [N-1:0] d;
    wr(1'b1, 4'h0, '0);
    idle(4'b1000);
    for (int i = 0; i < 5; i++) idle('0);
    check("R5 irq held", irq_pull_en, 1);
    rd(1'b0, '0, d); check("R5 uvlo still set", d, 4'b1000);
  endtask

  task automatic t_coincident();
    logic [N-1:0] d;
    idle(4'b0001);
    rd(1'b0, 4'b0010, d); check("R7 first read", d, 4'b0001);
    check("R7 irq kept", irq_pull_en, 1);
    rd(1'b0, '0, d); check("R7 new bit kept", d, 4'b0010);
  endtask

  task automatic t_write_status_ignored();
    logic [N-1:0] d;
    idle(4'b0101);
    wr(1'b0, 4'h0, '0);
    rd(1'b0, '0, d); check("R9 status after write", d, 4'b0101);
  endtask

  task automatic t_unmask_pending();
    logic [N-1:0] d;
    wr(1'b1, 4'hF, '0);
    idle(4'b1000);
    check("R10 masked pending quiet", irq_pull_en, 0);
    wr(1'b1, 4'b0111, '0);
    check("R10 unmask raises irq", irq_pull_en, 1);
    rd(1'b1, '0, d); check("R8 mask read", d, 4'b0111);
    rd(1'b0, '0, d); check("R8 R10 status intact", d, 4'b1000);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unmasked_event();
    t_masked_event();
    t_sticky();
    t_coincident();
    t_write_status_ignored();
    t_unmask_pending();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule